// File: doc/BRIEF.md
# Direct-Mapped Word Data Cache

This block sits between the load/store port of an in-order core and a line-wide backing memory. It holds 256 bytes in sixteen 16-byte lines, with one line per index. The core issues a single 32-bit word load or store and holds it until the cache raises its done strobe. A hit completes in the cycle the request is presented. A miss always takes four cycles. During a miss the cache fetches the whole line, installs it with its tag, and evicts whatever line held that index.

Stores write through. The cache updates its copy of the line, and in the completion cycle it writes the full updated line to memory, so no victim ever needs a writeback. A store miss allocates the line in the same way a load miss does. A request whose address is not word aligned is flagged and otherwise dropped. Two free-running 32-bit counters record completed hits and misses, so software can measure the hit rate.

Top module: `dm_dcache`

## Requirements
- R1: Address bits 7..4 choose one of 16 lines and bits 31..8 are the stored tag. Two addresses with the same index and different tags replace each other. Lines at different indices stay resident together.
- R2: After reset every line is invalid, so the first access to any address misses.
- R3: An aligned load that hits raises done in its first cycle. It returns the word that address bits 3..2 select within the line (0 = bytes 3..0, 3 = bytes 15..12).
- R4: An aligned load or store that misses raises done in its fourth cycle, counting the request cycle as the first. mem_rd is high in all four cycles, with mem_line_addr equal to address bits 31..4.
- R5: A store miss fetches the line and merges the store word into it. Later loads to that line hit and return the stored word.
- R6: Every aligned store drives mem_wr for exactly its completion cycle, with the full updated line on mem_wr_line. This applies to hits and to misses, so data survives eviction.
- R7: A miss evicts the line previously at its index, and a later load to the evicted line misses.
- R8: A request with address bits 1..0 not both zero completes in one cycle with rsp_misaligned high. It causes no memory read or write, no counter change and no change to the cache contents.
- R9: hit_count rises by one per completed hit and miss_count by one per completed miss. Reset clears both.
- R10: Only the missing line is fetched. A miss never fills any other index, so the next sequential line still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until rsp_done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| rsp_done | output | 1 | Request completes this cycle |
| rsp_rdata | output | 32 | Load data, valid with rsp_done on a load |
| rsp_misaligned | output | 1 | Request dropped as misaligned (with rsp_done) |
| mem_rd | output | 1 | Line fetch in progress |
| mem_wr | output | 1 | Line write-through this cycle |
| mem_line_addr | output | 28 | Line address (byte address bits 31..4) |
| mem_wr_line | output | 128 | Line written to memory |
| mem_rd_line | input | 128 | Line read from memory, needed in the last miss cycle |
| hit_count | output | 32 | Completed hits since reset |
| miss_count | output | 32 | Completed misses since reset |

## Verification
The assertions check the following on every cycle:
- A fetch that completes has lasted exactly the miss latency, with its line address held steady.
- Hit, miss and misaligned completions never occur together.
- Misaligned requests never touch memory.
- Every completed store writes through.
- Each counter moves only on its own completion event.

Some behaviour depends on what the tags and data hold, and only the bench scenarios can show it:
- Tag matching and conflict eviction between lines of equal index.
- Store-miss allocation and the returned word selection.
- The survival of written data after eviction.
- The absence of prefetch.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } dc_state_e;

  // true when the n lowest bits of a are all zero
  function automatic logic low_bits_clear(input logic [63:0] a, input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return (a & m) == 64'd0;
  endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic             valid_q [NUM_LINES];
  logic [TAG_W-1:0] tag_q   [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int LINE_W    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);

  logic [LINE_W-1:0] line_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        line_q[g] <= wr_line;
      end
    end
  end

  assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int MISS_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic aligned,
  input  logic lookup_hit,
  output logic hit_ev,
  output logic misal_ev,
  output logic miss_start,
  output logic fill_ev,
  output logic busy
);

  localparam int CNT_W = (MISS_CYCLES > 3) ? $clog2(MISS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(MISS_CYCLES - 3);

  dc_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit_ev     = (st_q == ST_LOOK) && req_valid && aligned && lookup_hit;
    misal_ev   = (st_q == ST_LOOK) && req_valid && !aligned;
    miss_start = (st_q == ST_LOOK) && req_valid && aligned && !lookup_hit;
    fill_ev    = (st_q == ST_FILL);
    busy       = (st_q != ST_LOOK);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_LOOK: begin
        cnt_d = '0;
        if (miss_start) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == WAIT_LAST) st_d = ST_FILL;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_FILL: st_d = ST_LOOK;
      default: st_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_LOOK;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dc_counter.sv
module dc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/dm_dcache.sv
module dm_dcache
  import dc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int NUM_LINES   = 16,
  parameter int MISS_CYCLES = 4,
  parameter int CNT_W       = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic [DATA_W-1:0]                  req_wdata,
  output logic                               rsp_done,
  output logic [DATA_W-1:0]                  rsp_rdata,
  output logic                               rsp_misaligned,
  output logic                               mem_rd,
  output logic                               mem_wr,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_line_addr,
  output logic [LINE_BYTES*8-1:0]            mem_wr_line,
  input  logic [LINE_BYTES*8-1:0]            mem_rd_line,
  output logic [CNT_W-1:0]                   hit_count,
  output logic [CNT_W-1:0]                   miss_count
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BSEL_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int LA_W   = ADDR_W - OFF_W;

  function automatic logic [DATA_W-1:0] line_word(input logic [LINE_W-1:0] ln,
                                                   input logic [WSEL_W-1:0] sel);
    return ln[sel*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] line_put(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] sel,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[sel*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  // request fields
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              req_aligned;

  assign req_tag     = req_addr[ADDR_W-1:OFF_W+IDX_W];
  assign req_idx     = req_addr[OFF_W+IDX_W-1:OFF_W];
  assign req_wsel    = req_addr[OFF_W-1:BSEL_W];
  assign req_aligned = low_bits_clear(64'(req_addr), BSEL_W);

  // request held for the length of a miss
  logic [ADDR_W-1:BSEL_W] lat_waddr;
  logic                   lat_write;
  logic [DATA_W-1:0]      lat_wdata;
  logic [TAG_W-1:0]       lat_tag;
  logic [IDX_W-1:0]       lat_idx;
  logic [WSEL_W-1:0]      lat_wsel;

  assign lat_tag  = lat_waddr[ADDR_W-1:OFF_W+IDX_W];
  assign lat_idx  = lat_waddr[OFF_W+IDX_W-1:OFF_W];
  assign lat_wsel = lat_waddr[OFF_W-1:BSEL_W];

  // named internal events
  logic              hit_ev, misal_ev, miss_start, fill_ev, busy;
  logic              lookup_hit, rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic [LINE_W-1:0] fill_line, hit_store_line;
  logic              store_hit;

  dc_tag_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .wr_en(fill_ev), .wr_idx(lat_idx), .wr_tag(lat_tag)
  );

  assign lookup_hit = rd_valid && (rd_tag == req_tag);

  dc_ctrl #(.MISS_CYCLES(MISS_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .aligned(req_aligned), .lookup_hit(lookup_hit),
    .hit_ev(hit_ev), .misal_ev(misal_ev), .miss_start(miss_start),
    .fill_ev(fill_ev), .busy(busy)
  );

  assign store_hit      = hit_ev && req_write;
  assign hit_store_line = line_put(rd_line, req_wsel, req_wdata);
  assign fill_line      = lat_write ? line_put(mem_rd_line, lat_wsel, lat_wdata) : mem_rd_line;

  dc_data_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) data_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_idx), .rd_line(rd_line),
    .wr_en(fill_ev || store_hit),
    .wr_idx(fill_ev ? lat_idx : req_idx),
    .wr_line(fill_ev ? fill_line : hit_store_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_waddr <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
    end else if (miss_start) begin
      lat_waddr <= req_addr[ADDR_W-1:BSEL_W];
      lat_write <= req_write;
      lat_wdata <= req_wdata;
    end
  end

  // processor side
  assign rsp_done       = hit_ev || misal_ev || fill_ev;
  assign rsp_misaligned = misal_ev;
  assign rsp_rdata      = fill_ev ? line_word(mem_rd_line, lat_wsel)
                                  : line_word(rd_line, req_wsel);

  // memory side
  assign mem_rd        = miss_start || busy;
  assign mem_line_addr = busy ? LA_W'(lat_waddr[ADDR_W-1:OFF_W]) : req_addr[ADDR_W-1:OFF_W];
  assign mem_wr        = store_hit || (fill_ev && lat_write);
  assign mem_wr_line   = fill_ev ? fill_line : hit_store_line;

  dc_counter #(.W(CNT_W)) hit_ctr_i  (.clk(clk), .rst_n(rst_n), .inc(hit_ev),  .count(hit_count));
  dc_counter #(.W(CNT_W)) miss_ctr_i (.clk(clk), .rst_n(rst_n), .inc(fill_ev), .count(miss_count));

endmodule

// File: rtl/dm_dcache_chk.sv
module dm_dcache_chk #(
  parameter int LA_W        = 28,
  parameter int MISS_CYCLES = 4,
  parameter int CNT_W       = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_done,
  input logic             rsp_misaligned,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [LA_W-1:0]  mem_line_addr,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic             hit_ev,
  input logic             fill_ev
);

  int unsigned miss_age;

  always_ff @(posedge clk) begin
    if (!rst_n)                  miss_age <= 0;
    else if (mem_rd && !rsp_done) miss_age <= miss_age + 1;
    else                         miss_age <= 0;
  end

  a_r4_miss_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && mem_rd) |-> (miss_age == MISS_CYCLES - 1));

  a_r4_line_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !rsp_done) |=> $stable(mem_line_addr));

  a_r10_fetch_ends_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && rsp_done) |-> fill_ev);

  a_r8_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_misaligned |-> (!mem_rd && !mem_wr && !hit_ev && !fill_ev));

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ev, fill_ev, rsp_misaligned}));

  a_r6_store_writes_through: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && req_valid && req_write && !rsp_misaligned) |-> mem_wr);

  a_r6_write_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> rsp_done);

  a_r9_hit_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> (hit_count == $past(hit_count) + CNT_W'(1)));

  a_r9_hit_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ev |=> $stable(hit_count));

  a_r9_miss_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |=> (miss_count == $past(miss_count) + CNT_W'(1)));

  a_r9_miss_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ev |=> $stable(miss_count));

endmodule

bind dm_dcache dm_dcache_chk #(
  .LA_W(LA_W), .MISS_CYCLES(MISS_CYCLES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_done(rsp_done), .rsp_misaligned(rsp_misaligned),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_line_addr(mem_line_addr),
  .hit_count(hit_count), .miss_count(miss_count),
  .hit_ev(hit_ev), .fill_ev(fill_ev)
);

// File: tb/dm_dcache_tb_top.sv
module dm_dcache_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_done, rsp_misaligned, mem_rd, mem_wr;
  logic [31:0]  rsp_rdata, hit_count, miss_count;
  logic [27:0]  mem_line_addr;
  logic [127:0] mem_wr_line;
  logic [127:0] mem_rd_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_dcache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_misaligned(rsp_misaligned), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_line_addr(mem_line_addr), .mem_wr_line(mem_wr_line),
    .mem_rd_line(mem_rd_line), .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_checks = 0;
  int n_fail = 0;

  // ---------------- backing memory model ----------------
  function automatic logic [31:0] init_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  logic [127:0] mem_q [logic [27:0]];
  int wr_tick = 0;

  function automatic logic [127:0] mem_line(input logic [27:0] la);
    logic [127:0] r;
    if (mem_q.exists(la)) return mem_q[la];
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = init_word({la, 4'h0} + 32'(w*4));
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_wr) begin
      mem_q[mem_line_addr] = mem_wr_line;
      wr_tick = wr_tick + 1;
    end
  end

  always @(mem_line_addr or wr_tick) mem_rd_line = mem_line(mem_line_addr);

  // ---------------- reference of stored words ----------------
  logic [31:0] gold [logic [31:0]];
  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return gold.exists(a) ? gold[a] : init_word(a);
  endfunction

  int exp_hits = 0;
  int exp_miss = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  // one access; latency counts cycles from request up to and including done
  int           a_lat;
  logic [31:0]  a_rdata;
  logic         a_mis, a_saw_rd, a_saw_wr;
  logic [27:0]  a_rd_la;
  logic [127:0] a_wr_ln;

  task automatic do_access(input logic wr, input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    a_lat = 0; a_saw_rd = 0; a_saw_wr = 0; a_mis = 0; a_rdata = '0; a_rd_la = '0; a_wr_ln = '0;
    for (int k = 0; k < 20; k++) begin
      a_lat++;
      #1;
      if (mem_rd) begin a_saw_rd = 1; a_rd_la = mem_line_addr; end
      if (mem_wr) begin a_saw_wr = 1; a_wr_ln = mem_wr_line; end
      if (rsp_done) begin
        a_rdata = rsp_rdata; a_mis = rsp_misaligned;
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        hit;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1000, 32'h0,         1'b0, 4'd2},  // cold miss
    '{1'b0, 32'h0000_1004, 32'h0,         1'b1, 4'd3},
    '{1'b0, 32'h0000_1008, 32'h0,         1'b1, 4'd3},
    '{1'b1, 32'h0000_2000, 32'hAAAA_0001, 1'b0, 4'd5},  // store miss allocates
    '{1'b0, 32'h0000_1004, 32'h0,         1'b0, 4'd7},  // evicted by the store
    '{1'b0, 32'h0000_100C, 32'h0,         1'b1, 4'd3},
    '{1'b0, 32'h0000_1010, 32'h0,         1'b0, 4'd10}, // next line not prefetched
    '{1'b1, 32'h0000_2004, 32'hBBBB_0002, 1'b0, 4'd5},
    '{1'b0, 32'h0000_2000, 32'h0,         1'b1, 4'd6},  // earlier store survived
    '{1'b0, 32'h0000_2004, 32'h0,         1'b1, 4'd5},
    '{1'b1, 32'h0000_2008, 32'hCCCC_0003, 1'b1, 4'd6},  // store hit
    '{1'b0, 32'h0000_1014, 32'h0,         1'b1, 4'd1},  // other index kept
    '{1'b0, 32'h0000_1008, 32'h0,         1'b0, 4'd7},
    '{1'b0, 32'h0000_2008, 32'h0,         1'b0, 4'd6},  // write-through reread
    '{1'b0, 32'h0000_0FF0, 32'h0,         1'b0, 4'd1},
    '{1'b0, 32'h0000_3FF0, 32'h0,         1'b0, 4'd1},  // same index, new tag
    '{1'b0, 32'h0000_0FFC, 32'h0,         1'b0, 4'd1},
    '{1'b0, 32'h0000_3FFC, 32'h0,         1'b0, 4'd7}
  };

  function automatic string rq_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd5: return "R5";   4'd6: return "R6";   4'd7: return "R7";
      4'd10: return "R10";
      default: return "R4";
    endcase
  endfunction

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    #1;
    check(!rsp_done && !mem_rd && !mem_wr, "R2", "idle outputs in reset",
          {rsp_done, mem_rd, mem_wr}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(hit_count == 0 && miss_count == 0, "R9", "counters after reset",
          {hit_count, miss_count}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = rq_name(v.rq);
      do_access(v.wr, v.addr, v.wdata);
      check(a_lat == (v.hit ? 1 : 4), v.hit ? "R3" : "R4", {t, " latency"},
            a_lat, v.hit ? 1 : 4);
      check(!a_mis, t, "misaligned flag", a_mis, 0);
      if (v.hit) exp_hits++; else exp_miss++;
      if (!v.hit)
        check(a_saw_rd && a_rd_la == v.addr[31:4], "R4", "fetch line address", a_rd_la, v.addr[31:4]);
      else
        check(!a_saw_rd, "R10", "no fetch on hit", a_saw_rd, 0);
      if (v.wr) begin
        gold[v.addr] = v.wdata;
        check(a_saw_wr && a_wr_ln[v.addr[3:2]*32 +: 32] == v.wdata, "R6",
              "write-through word", a_wr_ln[v.addr[3:2]*32 +: 32], v.wdata);
      end else begin
        check(a_rdata == exp_word(v.addr), t, "load data", a_rdata, exp_word(v.addr));
        check(!a_saw_wr, "R6", "no write on load", a_saw_wr, 0);
      end
      check(hit_count == 32'(exp_hits) && miss_count == 32'(exp_miss), "R9", "counters",
            {hit_count, miss_count}, {32'(exp_hits), 32'(exp_miss)});
    end

    // misaligned load: dropped
    do_access(1'b0, 32'h0000_2002, 32'h0);
    check(a_lat == 1 && a_mis, "R8", "misaligned load flagged", {a_lat, a_mis}, {32'd1, 1'b1});
    check(!a_saw_rd && !a_saw_wr, "R8", "misaligned load memory quiet", {a_saw_rd, a_saw_wr}, 0);
    check(hit_count == 32'(exp_hits) && miss_count == 32'(exp_miss), "R8", "counters unchanged",
          {hit_count, miss_count}, {32'(exp_hits), 32'(exp_miss)});

    // misaligned store: dropped, cached word untouched
    do_access(1'b1, 32'h0000_2009, 32'hDEAD_BEEF);
    check(a_lat == 1 && a_mis && !a_saw_wr && !a_saw_rd, "R8", "misaligned store dropped",
          {a_mis, a_saw_wr, a_saw_rd}, 3'b100);
    do_access(1'b0, 32'h0000_2008, 32'h0);
    exp_hits++;
    check(a_lat == 1 && a_rdata == 32'hCCCC_0003, "R8", "line unchanged after misaligned store",
          a_rdata, 32'hCCCC_0003);

    // second reset: counters cleared, lines invalid, memory keeps data
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(hit_count == 0 && miss_count == 0, "R9", "counters cleared by reset",
          {hit_count, miss_count}, 0);
    rst_n = 1'b1;
    do_access(1'b0, 32'h0000_2008, 32'h0);
    check(a_lat == 4, "R2", "miss after reset", a_lat, 4);
    check(a_rdata == 32'hCCCC_0003, "R6", "stored data in memory after reset", a_rdata, 32'hCCCC_0003);
    check(miss_count == 1 && hit_count == 0, "R9", "counters after reset access",
          {hit_count, miss_count}, {32'd0, 32'd1});

    finish_run();
  end

endmodule